// File: doc/BRIEF.md
# Reset Cause Status Register

This block records why the system last went through reset and offers that cause as a read-only status word. It watches four sources: an asynchronous, active-low power-on reset and three synchronous request levels (the external reset pin, the watchdog and software). The request levels are taken to be synchronous to the system clock already. At any time exactly one of four cause flags is set. When several sources are active in the same reset event, the flag of the strongest source wins. Power-on is strongest, then external, then watchdog, then software.

A small state machine tracks the reset event. It has three states. ST_POWERUP is forced asynchronously while power-on reset is active. ST_RUN is normal operation, where the recorded cause is held. ST_HELD means at least one reset request is present.

The transitions are named as follows:
- POWERUP_TO_HELD: taken at the first edge after power-on release if any request is present.
- POWERUP_TO_RUN: taken at that same edge if no request is present.
- RUN_TO_HELD: a new reset event begins.
- HELD_TO_HELD: a request is still present, and the cause may only move to a stronger source.
- HELD_TO_RUN: all requests have gone.

A separate output selects the watchdog reset vector instead of the normal one. It does so only when the watchdog flag is the recorded cause.

Top module: `reset_cause_reg`

## Requirements
- R1: While `por_n` is low, the status word is 0x0004 (power-on flag only), `vec_sel_wdog` is 0, and this takes effect without waiting for a clock edge.
- R2: With `rd_en` high, `rd_data` carries the status word. With `rd_en` low, `rd_data` is all zero. Status bits 15..6 and 1..0 always read as zero.
- R3: Exactly one of status bits 5..2 is set at all times.
- R4: The flag positions are: bit 5 software, bit 4 watchdog, bit 3 external, bit 2 power-on.
- R5: From ST_RUN, a request sampled at a clock edge starts a new event. The status shows the strongest active source after that edge. The order is external > watchdog > software.
- R6: While an event lasts, a stronger source that joins replaces the flag at the next edge. A weaker source that joins changes nothing, and the stronger flag stays after its own request drops.
- R7: At the first edge after power-on release, an active external request records the external flag. Watchdog or software requests at that edge leave the power-on flag in place.
- R8: While no request is present in ST_RUN, the status word does not change. A later event records its own cause even if that cause is weaker than the previous one.
- R9: `vec_sel_wdog` is 1 exactly when the watchdog flag (bit 4) is the recorded cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst | input | 1 | External reset pin level, active high |
| wdog_rst | input | 1 | Watchdog reset request level |
| sw_rst | input | 1 | Software reset request level |
| rd_en | input | 1 | Read strobe for the status word |
| rd_data | output | DATA_W | Status word when read, else zero |
| vec_sel_wdog | output | 1 | 1 selects the watchdog reset vector |

## Verification
The bench drives each source on its own from normal operation. Each of these events must light only its own flag, which shows the bit positions are not swapped. It then drives simultaneous pairs and triples, which show the fixed precedence rather than arrival order. Staggered arrivals, where a stronger or weaker source joins an event already in progress, separate precedence applied across the whole event from a cause that is only captured at entry. Power-on release with each request already active separates the special external override from the ordinary event path. Idle stretches followed by a weaker event show that the cause is held between events and replaced only by a new one.

// File: rtl/reset_cause_pkg.sv
package reset_cause_pkg;
    // cause vector index order is also precedence order (lowest index wins)
    localparam int RC_NSRC = 4;
    localparam int RC_LSB  = 2;          // status bit of cause index 0
    localparam int IDX_POR = 0;
    localparam int IDX_EXT = 1;
    localparam int IDX_WDG = 2;
    localparam int IDX_SW  = 3;

    typedef enum logic [1:0] {
        ST_POWERUP = 2'd0,
        ST_RUN     = 2'd1,
        ST_HELD    = 2'd2
    } rc_state_t;
endpackage

// File: rtl/rc_prio_pick.sv
module rc_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);
    logic [N-1:0] neg;
    always_comb begin
        neg  = ~req + N'(1);
        pick = req & neg;   // lowest set index survives
    end
endmodule

// File: rtl/rc_cause_fsm.sv
module rc_cause_fsm
    import reset_cause_pkg::*;
(
    input  logic               clk,
    input  logic               por_n,
    input  logic               ext_rst,
    input  logic               wdog_rst,
    input  logic               sw_rst,
    output logic [RC_NSRC-1:0] cause_q,
    output logic               in_powerup
);
    rc_state_t          state_q, state_d;
    logic [RC_NSRC-1:0] req_vec, pick_in, pick_out, cause_d;
    logic               cause_ld, any_req;

    always_comb begin
        req_vec          = '0;
        req_vec[IDX_EXT] = ext_rst;
        req_vec[IDX_WDG] = wdog_rst;
        req_vec[IDX_SW]  = sw_rst;
        any_req          = |req_vec;
    end

    rc_prio_pick #(.N(RC_NSRC)) u_pick (
        .req  (pick_in),
        .pick (pick_out)
    );

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_POWERUP;
        else        state_q <= state_d;
    end

    // cause register: power-on flag forced asynchronously
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cause_q          <= '0;
            cause_q[IDX_POR] <= 1'b1;
        end else if (cause_ld) begin
            cause_q <= cause_d;
        end
    end

    // next state and load decisions
    always_comb begin
        state_d  = state_q;
        cause_ld = 1'b0;
        pick_in  = req_vec;
        cause_d  = pick_out;
        unique case (state_q)
            ST_POWERUP: begin
                if (any_req) begin
                    state_d = ST_HELD;                 // POWERUP_TO_HELD
                    if (ext_rst) begin
                        cause_ld         = 1'b1;
                        cause_d          = '0;
                        cause_d[IDX_EXT] = 1'b1;
                    end
                end else begin
                    state_d = ST_RUN;                  // POWERUP_TO_RUN
                end
            end
            ST_RUN: begin
                if (any_req) begin
                    state_d  = ST_HELD;                // RUN_TO_HELD
                    cause_ld = 1'b1;
                end
            end
            ST_HELD: begin
                if (any_req) begin
                    pick_in  = req_vec | cause_q;      // HELD_TO_HELD
                    cause_ld = 1'b1;
                end else begin
                    state_d = ST_RUN;                  // HELD_TO_RUN
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign in_powerup = (state_q == ST_POWERUP);
endmodule

// File: rtl/rc_read_port.sv
module rc_read_port
    import reset_cause_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [RC_NSRC-1:0] cause,
    input  logic               rd_en,
    output logic [DATA_W-1:0]  rd_data,
    output logic               vec_sel_wdog
);
    localparam int HI_W = DATA_W - RC_NSRC - RC_LSB;
    logic [DATA_W-1:0] status;

    always_comb begin
        status = {{HI_W{1'b0}}, cause, {RC_LSB{1'b0}}};
        rd_data = rd_en ? status : '0;
        vec_sel_wdog = cause[IDX_WDG];
    end
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
    import reset_cause_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst,
    input  logic              wdog_rst,
    input  logic              sw_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              vec_sel_wdog
);
    logic [RC_NSRC-1:0] cause_w;
    logic               in_pu_w;

    rc_cause_fsm u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .ext_rst    (ext_rst),
        .wdog_rst   (wdog_rst),
        .sw_rst     (sw_rst),
        .cause_q    (cause_w),
        .in_powerup (in_pu_w)
    );

    rc_read_port #(.DATA_W(DATA_W)) u_rd (
        .cause        (cause_w),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .vec_sel_wdog (vec_sel_wdog)
    );
endmodule

// File: rtl/reset_cause_chk.sv
module reset_cause_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              por_n,
    input logic              ext_rst,
    input logic              wdog_rst,
    input logic              sw_rst,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              vec_sel_wdog,
    input logic [3:0]        cause,
    input logic              in_pu
);
    AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        $countones(cause) == 1); // R3
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        rd_en |-> (rd_data[DATA_W-1:6] == '0 && rd_data[1:0] == 2'b00)); // R2
    AST_VEC_FROM_WDOG: assert property (@(posedge clk) disable iff (!por_n)
        $rose(vec_sel_wdog) |-> $past(wdog_rst)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (!ext_rst && !wdog_rst && !sw_rst && !in_pu) |=> $stable(cause)); // R8
    AST_SW_WEAKEST: assert property (@(posedge clk) disable iff (!por_n)
        $rose(cause[3]) |-> $past(!ext_rst && !wdog_rst)); // R5
    AST_EXT_NEEDS_PIN: assert property (@(posedge clk) disable iff (!por_n)
        $rose(cause[1]) |-> $past(ext_rst)); // R7
endmodule

bind reset_cause_reg reset_cause_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .ext_rst      (ext_rst),
    .wdog_rst     (wdog_rst),
    .sw_rst       (sw_rst),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .vec_sel_wdog (vec_sel_wdog),
    .cause        (cause_w),
    .in_pu        (in_pu_w)
);

// File: tb/tb_reset_cause_reg.sv
`timescale 1ns/1ps
module tb_reset_cause_reg;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        ext_rst = 1'b0, wdog_rst = 1'b0, sw_rst = 1'b0;
    logic        rd_en = 1'b1;
    logic [15:0] rd_data;
    logic        vec_sel_wdog;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    localparam logic [15:0] V_POR = 16'h0004, V_EXT = 16'h0008,
                            V_WDG = 16'h0010, V_SW = 16'h0020;

    always #2.5 clk = ~clk;

    reset_cause_reg dut (
        .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .wdog_rst(wdog_rst),
        .sw_rst(sw_rst), .rd_en(rd_en), .rd_data(rd_data),
        .vec_sel_wdog(vec_sel_wdog)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic set_req(input logic e, input logic w, input logic s);
        ext_rst = e; wdog_rst = w; sw_rst = s;
    endtask

    task automatic t_por_async;
        set_req(0, 1, 0); step(); // record watchdog first
        set_req(0, 0, 0); step();
        #1 por_n = 1'b0; #0.5;
        chk("R1 async por status", rd_data, V_POR);
        chk("R1 async por vec", {15'd0, vec_sel_wdog}, 16'd0);
        @(negedge clk); por_n = 1'b1; step();
        chk("R4 por flag after release", rd_data, V_POR);
    endtask

    task automatic t_por_ext;
        por_n = 1'b0; set_req(1, 0, 0);
        @(negedge clk); por_n = 1'b1; step();
        chk("R7 ext after por release", rd_data, V_EXT);
        set_req(0, 0, 0); step();
        chk("R7 ext held", rd_data, V_EXT);
    endtask

    task automatic t_por_weak;
        por_n = 1'b0; set_req(0, 1, 1);
        @(negedge clk); por_n = 1'b1; step();
        chk("R7 wdog/sw keep por", rd_data, V_POR);
        chk("R9 vec low under por", {15'd0, vec_sel_wdog}, 16'd0);
        set_req(0, 0, 0); step();
    endtask

    task automatic t_single;
        set_req(0, 0, 1); step();
        chk("R4 sw bit5", rd_data, V_SW);
        set_req(0, 0, 0); step();
        set_req(0, 1, 0); step();
        chk("R4 wdog bit4", rd_data, V_WDG);
        chk("R9 vec high on wdog", {15'd0, vec_sel_wdog}, 16'd1);
        set_req(0, 0, 0); step();
        set_req(1, 0, 0); step();
        chk("R4 ext bit3", rd_data, V_EXT);
        chk("R9 vec low on ext", {15'd0, vec_sel_wdog}, 16'd0);
        set_req(0, 0, 0); step();
    endtask

    task automatic t_multi;
        set_req(0, 1, 1); step();
        chk("R5 wdog beats sw", rd_data, V_WDG);
        set_req(0, 0, 0); step();
        set_req(1, 1, 1); step();
        chk("R5 ext beats all", rd_data, V_EXT);
        set_req(0, 0, 0); step();
        set_req(1, 0, 1); step();
        chk("R5 ext beats sw", rd_data, V_EXT);
        set_req(0, 0, 0); step();
    endtask

    task automatic t_upgrade;
        set_req(0, 0, 1); step();
        chk("R6 start sw", rd_data, V_SW);
        set_req(0, 1, 1); step();
        chk("R6 wdog joins", rd_data, V_WDG);
        set_req(1, 1, 1); step();
        chk("R6 ext joins", rd_data, V_EXT);
        set_req(0, 1, 0); step();
        chk("R6 ext kept after drop", rd_data, V_EXT);
        set_req(0, 0, 0); step();
        set_req(0, 1, 0); step();
        set_req(0, 1, 1); step();
        chk("R6 weaker join ignored", rd_data, V_WDG);
        set_req(0, 0, 0); step();
    endtask

    task automatic t_hold;
        step(5);
        chk("R8 idle hold", rd_data, V_WDG);
        set_req(0, 0, 1); step();
        chk("R8 new weaker event", rd_data, V_SW);
        set_req(0, 0, 0); step(3);
        chk("R8 hold after event", rd_data, V_SW);
        chk("R3 single flag", 16'($countones(rd_data)), 16'd1);
    endtask

    task automatic t_read;
        rd_en = 1'b0; #0.5;
        chk("R2 no read gives zero", rd_data, 16'h0000);
        rd_en = 1'b1; #0.5;
        chk("R2 read gives status", rd_data, V_SW);
    endtask

    initial begin
        step(2);
        chk("R1 reset status", rd_data, V_POR);
        chk("R1 reset vec", {15'd0, vec_sel_wdog}, 16'd0);
        por_n = 1'b1; step();
        chk("R1 por kept idle", rd_data, V_POR);
        t_por_async();
        t_por_ext();
        t_por_weak();
        t_single();
        t_multi();
        t_upgrade();
        t_hold();
        t_read();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule